// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block sits at the end of a display pixel pipeline. It lays a 64x64 sprite over the stream of display pixels. Each sprite pixel is a two-bit code. Code 00 shows cursor colour 0 and code 01 shows cursor colour 1. Code 10 is see-through, and code 11 shows the bitwise inverse of the display pixel beneath it. The sprite is held in a 1024-byte internal store, 16 bytes per sprite line, loaded through a byte-wide write port.

For each display pixel the block receives the x and y counters of the timing generator, an active flag and the display pixel value. Two clocks later it returns the merged pixel. Software places the sprite through a screen position, a horizontal and a vertical sprite offset, and a line-start pointer into the store. To clip the sprite at the left or top screen edge, software clamps the position to 0 and moves the offsets and the pointer forward. A doublescan flag makes the vertical position count in doubled scanlines. All settings are copied into shadow registers only on a frame-start pulse, so a moving cursor never tears.

A small sequencer controls the block and has three states. FILL writes the see-through pattern 0xAA into every byte after reset and always passes pixels through. It moves to WAIT when the last byte has been written. WAIT holds until the first frame start. On that pulse it takes the first copy of the settings and moves to LIVE. LIVE is the working state: it re-copies the settings on every frame start and stays there until reset.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, the sequencer spends 1024 cycles in FILL, writing 0xAA to every byte of the store. In FILL and in WAIT every pixel passes through unchanged. Host writes and frame-start pulses that arrive during FILL are dropped.
- R2: `out_data` and `out_active` give the result for the pixel presented two clock edges earlier. Both are 0 while reset is held.
- R3: Inside the sprite, code 00 outputs the shadowed colour 0 and code 01 outputs the shadowed colour 1.
- R4: Code 10 outputs the display pixel unchanged.
- R5: Code 11 outputs the ones' complement of the display pixel.
- R6: The sprite covers screen columns pos_x to pos_x+63-hoff and lines ystart to ystart+63-voff, where ystart is pos_y. Pixels outside that window, and pixels with `pix_active` low, pass through.
- R7: Sprite column c of drawn line k reads the byte at (line_base*8 + k*16 + c/4) mod 1024. Its code sits in bits [2*(c%4)+1 : 2*(c%4)] of that byte, so the lowest bit pair is drawn first.
- R8: The screen column pos_x shows sprite column hoff, which clips hoff columns from the left edge of the sprite.
- R9: Exactly 64-voff lines are drawn. Drawn line k appears on screen line ystart+k.
- R10: With doublescan set, ystart is 2*pos_y and each sprite line covers two scanlines, so the window is 2*(64-voff) scanlines tall.
- R11: With the shadowed enable at 0, every pixel passes through.
- R12: Setting inputs are copied only on a `frame_start` pulse. Changes made between pulses have no effect on the output.
- R13: In WAIT and LIVE, a host write replaces one byte of the store, and that byte is seen by every later pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Store write strobe |
| host_addr | input | 10 | Store byte address |
| host_wdata | input | 8 | Store write byte |
| cfg_enable | input | 1 | Cursor enable |
| cfg_dblscan | input | 1 | Doublescan flag |
| cfg_color0 | input | 8 | Colour for code 00 |
| cfg_color1 | input | 8 | Colour for code 01 |
| cfg_pos_x | input | 12 | Screen column of the drawn area's left edge |
| cfg_pos_y | input | 12 | Screen line of the drawn area's top edge |
| cfg_hoff | input | 6 | First sprite column drawn |
| cfg_voff | input | 6 | Number of lines not drawn |
| cfg_line_base | input | 7 | Store address of the first drawn line, in 8-byte units |
| frame_start | input | 1 | One-cycle pulse that copies the settings into the shadow registers |
| pix_x | input | 12 | Current pixel column |
| pix_y | input | 12 | Current pixel line |
| pix_active | input | 1 | Pixel is in the visible area |
| pix_data | input | 8 | Display pixel beneath the cursor |
| out_data | output | 8 | Merged pixel |
| out_active | output | 1 | Delayed active flag |

## Verification
The bench probes the edges of the drawn window: the first and last drawn columns and lines, one step beyond each, and the same edges after they move under hoff, voff and doublescan. An off-by-one in the span compare would draw or drop a stray column or line, and a doublescan bug would stretch the window or start it on the wrong line. It loads bytes whose four bit pairs differ and lines away from the line base. A reversed pixel order within a byte, or a wrong line stride, then shows the wrong colour at a known spot. It also sends host writes and frame-start pulses during the reset fill, and changes settings without a frame-start pulse. A design that fails to drop or hold these would paint the cursor from stale or unintended data.

// File: rtl/cur_pkg.sv
`timescale 1ns/1ps
package cur_pkg;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_WAIT = 2'd1,
        ST_LIVE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        CODE_CLR0 = 2'b00,
        CODE_CLR1 = 2'b01,
        CODE_SEE  = 2'b10,
        CODE_INV  = 2'b11
    } sprite_code_e;

    localparam logic [7:0] SEE_THROUGH_BYTE = 8'hAA;

    function automatic sprite_code_e pick_code(input logic [7:0] b, input logic [1:0] sel);
        logic [1:0] raw;
        raw = b[{sel, 1'b0} +: 2];
        return sprite_code_e'(raw);
    endfunction

endpackage

// File: rtl/cur_seq.sv
`timescale 1ns/1ps
module cur_seq
    import cur_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int COORD_W = 12,
    parameter int SPR_BITS = 6,
    parameter int ADDR_W  = 10,
    parameter int BASE_W  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                cfg_enable,
    input  logic                cfg_dblscan,
    input  logic [PIX_W-1:0]    cfg_color0,
    input  logic [PIX_W-1:0]    cfg_color1,
    input  logic [COORD_W-1:0]  cfg_pos_x,
    input  logic [COORD_W-1:0]  cfg_pos_y,
    input  logic [SPR_BITS-1:0] cfg_hoff,
    input  logic [SPR_BITS-1:0] cfg_voff,
    input  logic [BASE_W-1:0]   cfg_line_base,
    output logic                live,
    output logic                host_ok,
    output logic                fill_we,
    output logic [ADDR_W-1:0]   fill_addr,
    output logic                sh_en,
    output logic                sh_dbl,
    output logic [PIX_W-1:0]    sh_clr0,
    output logic [PIX_W-1:0]    sh_clr1,
    output logic [COORD_W-1:0]  sh_pos_x,
    output logic [COORD_W-1:0]  sh_pos_y,
    output logic [SPR_BITS-1:0] sh_hoff,
    output logic [SPR_BITS-1:0] sh_voff,
    output logic [BASE_W-1:0]   sh_base
);

    seq_state_e state_q, state_d;
    logic       fill_last;
    logic       latch;

    assign fill_last = &fill_addr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (fill_last)   state_d = ST_WAIT;
            ST_WAIT: if (frame_start) state_d = ST_LIVE;
            ST_LIVE: state_d = ST_LIVE;
            default: state_d = ST_FILL;
        endcase
    end

    // outputs of the state
    always_comb begin
        fill_we = 1'b0;
        host_ok = 1'b0;
        live    = 1'b0;
        latch   = 1'b0;
        unique case (state_q)
            ST_FILL: fill_we = 1'b1;
            ST_WAIT: begin host_ok = 1'b1; latch = frame_start; end
            ST_LIVE: begin host_ok = 1'b1; latch = frame_start; live = 1'b1; end
            default: fill_we = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       fill_addr <= '0;
        else if (fill_we) fill_addr <= fill_addr + 1'b1;
    end

    // shadow settings, copied only at a frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_en    <= 1'b0;
            sh_dbl   <= 1'b0;
            sh_clr0  <= '0;
            sh_clr1  <= '0;
            sh_pos_x <= '0;
            sh_pos_y <= '0;
            sh_hoff  <= '0;
            sh_voff  <= '0;
            sh_base  <= '0;
        end else if (latch) begin
            sh_en    <= cfg_enable;
            sh_dbl   <= cfg_dblscan;
            sh_clr0  <= cfg_color0;
            sh_clr1  <= cfg_color1;
            sh_pos_x <= cfg_pos_x;
            sh_pos_y <= cfg_pos_y;
            sh_hoff  <= cfg_hoff;
            sh_voff  <= cfg_voff;
            sh_base  <= cfg_line_base;
        end
    end

    assert_fill_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && !fill_last) |=> (state_q == ST_FILL));

    assert_fill_leaves_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && fill_last) |=> (state_q == ST_WAIT));

    assert_shadow_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(sh_pos_x) && $stable(sh_pos_y) && $stable(sh_en)
                          && $stable(sh_base) && $stable(sh_clr0)));

endmodule

// File: rtl/cur_spram.sv
`timescale 1ns/1ps
module cur_spram #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        rdata <= store[raddr];
    end

endmodule

// File: rtl/cur_locate.sv
`timescale 1ns/1ps
module cur_locate #(
    parameter int PIX_W    = 8,
    parameter int COORD_W  = 12,
    parameter int SPR_DIM  = 64,
    parameter int SPR_BITS = 6,
    parameter int LINE_SH  = 4,
    parameter int ADDR_W   = 10,
    parameter int UNIT_SH  = 3,
    parameter int BASE_W   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                live,
    input  logic                en,
    input  logic                dbl,
    input  logic [COORD_W-1:0]  pos_x,
    input  logic [COORD_W-1:0]  pos_y,
    input  logic [SPR_BITS-1:0] hoff,
    input  logic [SPR_BITS-1:0] voff,
    input  logic [BASE_W-1:0]   base,
    input  logic [COORD_W-1:0]  pix_x,
    input  logic [COORD_W-1:0]  pix_y,
    input  logic                pix_active,
    input  logic [PIX_W-1:0]    pix_data,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic                s1_hit,
    output logic [1:0]          s1_sel,
    output logic [PIX_W-1:0]    s1_pix,
    output logic                s1_act
);

    localparam int W = COORD_W + 2;

    logic [W-1:0]        x_w, y_w, px_w, ystart, dx, dy, row_w, span_x, span_y;
    logic                in_x, in_y, hit;
    logic [SPR_BITS-1:0] col, row;

    always_comb begin
        x_w    = W'(pix_x);
        y_w    = W'(pix_y);
        px_w   = W'(pos_x);
        ystart = dbl ? W'({pos_y, 1'b0}) : W'(pos_y);
        dx     = x_w - px_w;
        dy     = y_w - ystart;
        row_w  = dbl ? {1'b0, dy[W-1:1]} : dy;
        span_x = W'(SPR_DIM) - W'(hoff);
        span_y = W'(SPR_DIM) - W'(voff);
        in_x   = (x_w >= px_w)   && (dx < span_x);
        in_y   = (y_w >= ystart) && (row_w < span_y);
        hit    = live && en && pix_active && in_x && in_y;
        col    = hoff + dx[SPR_BITS-1:0];
        row    = row_w[SPR_BITS-1:0];
        rd_addr = {base, {UNIT_SH{1'b0}}}
                + {row, {LINE_SH{1'b0}}}
                + ADDR_W'(col[SPR_BITS-1:2]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_hit <= 1'b0;
            s1_sel <= '0;
            s1_pix <= '0;
            s1_act <= 1'b0;
        end else begin
            s1_hit <= hit;
            s1_sel <= col[1:0];
            s1_pix <= pix_data;
            s1_act <= pix_active;
        end
    end

    assert_disabled_no_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !s1_hit);

    assert_not_live_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> !s1_hit);

    assert_inactive_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_active |=> !s1_hit);

endmodule

// File: rtl/cur_merge.sv
`timescale 1ns/1ps
module cur_merge
    import cur_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s1_hit,
    input  logic [1:0]       s1_sel,
    input  logic [PIX_W-1:0] s1_pix,
    input  logic             s1_act,
    input  logic [7:0]       rdata,
    input  logic [PIX_W-1:0] clr0,
    input  logic [PIX_W-1:0] clr1,
    output logic [PIX_W-1:0] out_data,
    output logic             out_active
);

    sprite_code_e    code;
    logic [PIX_W-1:0] merged;

    always_comb begin
        code   = pick_code(rdata, s1_sel);
        merged = s1_pix;
        if (s1_hit) begin
            unique case (code)
                CODE_CLR0: merged = clr0;
                CODE_CLR1: merged = clr1;
                CODE_SEE:  merged = s1_pix;
                CODE_INV:  merged = ~s1_pix;
                default:   merged = s1_pix;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data   <= '0;
            out_active <= 1'b0;
        end else begin
            out_data   <= merged;
            out_active <= s1_act;
        end
    end

    assert_see_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_hit && code == CODE_SEE) |=> (out_data == $past(s1_pix)));

    assert_invert_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_hit && code == CODE_INV) |=> (out_data == ~$past(s1_pix)));

    assert_colour0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_hit && code == CODE_CLR0) |=> (out_data == $past(clr0)));

    assert_miss_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_hit |=> (out_data == $past(s1_pix)));

endmodule

// File: rtl/cursor_overlay.sv
`timescale 1ns/1ps
module cursor_overlay
    import cur_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int COORD_W = 12,
    parameter int SPR_DIM = 64,
    parameter int SPR_BITS = $clog2(SPR_DIM),
    parameter int ADDR_W  = $clog2(SPR_DIM * SPR_DIM / 4),
    parameter int BASE_W  = ADDR_W - 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [7:0]          host_wdata,
    input  logic                cfg_enable,
    input  logic                cfg_dblscan,
    input  logic [PIX_W-1:0]    cfg_color0,
    input  logic [PIX_W-1:0]    cfg_color1,
    input  logic [COORD_W-1:0]  cfg_pos_x,
    input  logic [COORD_W-1:0]  cfg_pos_y,
    input  logic [SPR_BITS-1:0] cfg_hoff,
    input  logic [SPR_BITS-1:0] cfg_voff,
    input  logic [BASE_W-1:0]   cfg_line_base,
    input  logic                frame_start,
    input  logic [COORD_W-1:0]  pix_x,
    input  logic [COORD_W-1:0]  pix_y,
    input  logic                pix_active,
    input  logic [PIX_W-1:0]    pix_data,
    output logic [PIX_W-1:0]    out_data,
    output logic                out_active
);

    localparam int BYTES_PER_LINE = SPR_DIM / 4;
    localparam int LINE_SH        = $clog2(BYTES_PER_LINE);
    localparam int UNIT_SH        = ADDR_W - BASE_W;

    logic                live, host_ok, fill_we;
    logic [ADDR_W-1:0]   fill_addr, rd_addr, wr_addr;
    logic                wr_en;
    logic [7:0]          wr_data, rdata;
    logic                sh_en, sh_dbl;
    logic [PIX_W-1:0]    sh_clr0, sh_clr1;
    logic [COORD_W-1:0]  sh_pos_x, sh_pos_y;
    logic [SPR_BITS-1:0] sh_hoff, sh_voff;
    logic [BASE_W-1:0]   sh_base;
    logic                s1_hit, s1_act;
    logic [1:0]          s1_sel;
    logic [PIX_W-1:0]    s1_pix;

    cur_seq #(
        .PIX_W(PIX_W), .COORD_W(COORD_W), .SPR_BITS(SPR_BITS),
        .ADDR_W(ADDR_W), .BASE_W(BASE_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_enable(cfg_enable), .cfg_dblscan(cfg_dblscan),
        .cfg_color0(cfg_color0), .cfg_color1(cfg_color1),
        .cfg_pos_x(cfg_pos_x), .cfg_pos_y(cfg_pos_y),
        .cfg_hoff(cfg_hoff), .cfg_voff(cfg_voff), .cfg_line_base(cfg_line_base),
        .live(live), .host_ok(host_ok), .fill_we(fill_we), .fill_addr(fill_addr),
        .sh_en(sh_en), .sh_dbl(sh_dbl), .sh_clr0(sh_clr0), .sh_clr1(sh_clr1),
        .sh_pos_x(sh_pos_x), .sh_pos_y(sh_pos_y), .sh_hoff(sh_hoff),
        .sh_voff(sh_voff), .sh_base(sh_base)
    );

    // fill has the port during FILL; host writes are dropped there
    always_comb begin
        if (fill_we) begin
            wr_en   = 1'b1;
            wr_addr = fill_addr;
            wr_data = SEE_THROUGH_BYTE;
        end else begin
            wr_en   = host_we && host_ok;
            wr_addr = host_addr;
            wr_data = host_wdata;
        end
    end

    cur_spram #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(rdata)
    );

    cur_locate #(
        .PIX_W(PIX_W), .COORD_W(COORD_W), .SPR_DIM(SPR_DIM), .SPR_BITS(SPR_BITS),
        .LINE_SH(LINE_SH), .ADDR_W(ADDR_W), .UNIT_SH(UNIT_SH), .BASE_W(BASE_W)
    ) u_locate (
        .clk(clk), .rst_n(rst_n), .live(live), .en(sh_en), .dbl(sh_dbl),
        .pos_x(sh_pos_x), .pos_y(sh_pos_y), .hoff(sh_hoff), .voff(sh_voff),
        .base(sh_base), .pix_x(pix_x), .pix_y(pix_y), .pix_active(pix_active),
        .pix_data(pix_data), .rd_addr(rd_addr), .s1_hit(s1_hit), .s1_sel(s1_sel),
        .s1_pix(s1_pix), .s1_act(s1_act)
    );

    cur_merge #(.PIX_W(PIX_W)) u_merge (
        .clk(clk), .rst_n(rst_n), .s1_hit(s1_hit), .s1_sel(s1_sel),
        .s1_pix(s1_pix), .s1_act(s1_act), .rdata(rdata),
        .clr0(sh_clr0), .clr1(sh_clr1),
        .out_data(out_data), .out_active(out_active)
    );

    assert_host_write_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> (wr_data == SEE_THROUGH_BYTE && wr_addr == fill_addr));

endmodule

// File: tb/cursor_overlay_tb.sv
`timescale 1ns/1ps
module cursor_overlay_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        cfg_enable = 1'b0, cfg_dblscan = 1'b0;
    logic [7:0]  cfg_color0 = '0, cfg_color1 = '0;
    logic [11:0] cfg_pos_x = '0, cfg_pos_y = '0;
    logic [5:0]  cfg_hoff = '0, cfg_voff = '0;
    logic [6:0]  cfg_line_base = '0;
    logic        frame_start = 1'b0;
    logic [11:0] pix_x = '0, pix_y = '0;
    logic        pix_active = 1'b0;
    logic [7:0]  pix_data = '0;
    logic [7:0]  out_data;
    logic        out_active;

    int n_chk = 0;
    int n_fail = 0;

    // bench model
    logic [7:0] bm_mem [1024];
    bit bm_ready = 0, bm_live = 0;
    bit m_en, m_dbl;
    int m_px, m_py, m_hoff, m_voff, m_base;
    logic [7:0] m_c0, m_c1;

    always #2.5 clk = ~clk;

    cursor_overlay u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .cfg_enable(cfg_enable), .cfg_dblscan(cfg_dblscan),
        .cfg_color0(cfg_color0), .cfg_color1(cfg_color1), .cfg_pos_x(cfg_pos_x),
        .cfg_pos_y(cfg_pos_y), .cfg_hoff(cfg_hoff), .cfg_voff(cfg_voff),
        .cfg_line_base(cfg_line_base), .frame_start(frame_start), .pix_x(pix_x),
        .pix_y(pix_y), .pix_active(pix_active), .pix_data(pix_data),
        .out_data(out_data), .out_active(out_active)
    );

    function automatic logic [7:0] model_pix(int x, int y, bit act, logic [7:0] pv);
        int ys, dx, dy, k, c, a, cd;
        if (!act || !bm_live || !m_en) return pv;
        ys = m_dbl ? 2 * m_py : m_py;
        if (x < m_px || y < ys) return pv;
        dx = x - m_px;
        dy = y - ys;
        k  = m_dbl ? dy / 2 : dy;
        if (dx >= 64 - m_hoff || k >= 64 - m_voff) return pv;
        c  = m_hoff + dx;
        a  = (m_base * 8 + k * 16 + c / 4) % 1024;
        cd = (bm_mem[a] >> (2 * (c % 4))) & 3;
        case (cd)
            0: return m_c0;
            1: return m_c1;
            2: return pv;
            default: return ~pv;
        endcase
    endfunction

    task automatic check_pix(int x, int y, bit act, logic [7:0] pv, string tag);
        logic [7:0] exp;
        exp = model_pix(x, y, act, pv);
        @(negedge clk);
        pix_x = 12'(x); pix_y = 12'(y); pix_active = act; pix_data = pv;
        @(posedge clk); #1;
        pix_x = '0; pix_y = '0; pix_active = 1'b0; pix_data = 8'h00;
        @(posedge clk); #1;
        n_chk++;
        if (out_data !== exp || out_active !== act) begin
            n_fail++;
            $display("FAIL %s at (%0d,%0d): got data %h act %b, expected %h act %b",
                     tag, x, y, out_data, out_active, exp, act);
        end
    endtask

    task automatic wr(int addr, logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 10'(addr); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        if (bm_ready) bm_mem[addr] = d;
    endtask

    task automatic set_cfg(bit en, bit dbl, int px, int py, int ho, int vo, int base);
        cfg_enable = en; cfg_dblscan = dbl;
        cfg_pos_x = 12'(px); cfg_pos_y = 12'(py);
        cfg_hoff = 6'(ho); cfg_voff = 6'(vo); cfg_line_base = 7'(base);
    endtask

    task automatic frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        if (bm_ready) begin
            bm_live = 1;
            m_en = cfg_enable; m_dbl = cfg_dblscan;
            m_px = int'(cfg_pos_x); m_py = int'(cfg_pos_y);
            m_hoff = int'(cfg_hoff); m_voff = int'(cfg_voff);
            m_base = int'(cfg_line_base);
            m_c0 = cfg_color0; m_c1 = cfg_color1;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got no finish, expected run end");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 1024; i++) bm_mem[i] = 8'hAA;
        cfg_color0 = 8'h3C; cfg_color1 = 8'hC3;
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (out_data !== 8'h00 || out_active !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 reset: got %h/%b expected 00/0", out_data, out_active);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1: during fill, writes and frame pulses are dropped
        set_cfg(1, 0, 0, 0, 0, 0, 0);
        frame();
        wr(0, 8'h00);
        check_pix(0, 0, 1, 8'h5A, "R1 fill passthrough");
        repeat (1100) @(posedge clk);
        bm_ready = 1;
        check_pix(0, 0, 1, 8'h5A, "R1 wait passthrough");
        frame();
        check_pix(0, 0, 1, 8'h5A, "R1 fill pattern");
        check_pix(5, 3, 1, 8'h17, "R1 fill pattern");

        // R3 R4 R5 R7: byte codes and pixel order in a byte
        wr(0, 8'hE4);
        wr(15, 8'h00);
        wr(1023, 8'h55);
        set_cfg(1, 0, 100, 50, 0, 0, 0);
        frame();
        check_pix(100, 50, 1, 8'h5A, "R3 colour0");
        check_pix(101, 50, 1, 8'h5A, "R3 colour1");
        check_pix(102, 50, 1, 8'h5A, "R4 see-through");
        check_pix(103, 50, 1, 8'h5A, "R5 invert");
        check_pix(103, 50, 0, 8'h5A, "R6 inactive");
        // R6 footprint edges
        check_pix(99, 50, 1, 8'h21, "R6 left edge");
        check_pix(163, 50, 1, 8'h21, "R6 last column");
        check_pix(164, 50, 1, 8'h21, "R6 right edge");
        check_pix(100, 49, 1, 8'h21, "R6 top edge");
        check_pix(163, 113, 1, 8'h21, "R7 last byte");
        check_pix(163, 114, 1, 8'h21, "R6 bottom edge");

        // R8 left clip
        set_cfg(1, 0, 0, 50, 2, 0, 0);
        frame();
        check_pix(0, 50, 1, 8'h66, "R8 first column");
        check_pix(1, 50, 1, 8'h66, "R8 second column");
        check_pix(61, 50, 1, 8'h66, "R8 last column");
        check_pix(62, 50, 1, 8'h66, "R8 past span");

        // R9 top clip with line base
        wr(16, 8'h01);
        wr(864, 8'h00);
        set_cfg(1, 0, 10, 0, 0, 10, 2);
        frame();
        check_pix(10, 0, 1, 8'h0F, "R9 first line");
        check_pix(10, 53, 1, 8'h0F, "R9 last line");
        check_pix(10, 54, 1, 8'h0F, "R9 past span");

        // R10 doublescan
        wr(1008, 8'h00);
        set_cfg(1, 1, 30, 20, 0, 0, 0);
        frame();
        check_pix(30, 39, 1, 8'h44, "R10 above");
        check_pix(30, 40, 1, 8'h44, "R10 row0 a");
        check_pix(31, 41, 1, 8'h44, "R10 row0 b");
        check_pix(30, 42, 1, 8'h44, "R10 row1");
        check_pix(30, 167, 1, 8'h44, "R10 last");
        check_pix(30, 168, 1, 8'h44, "R10 below");

        // R11 disable
        set_cfg(0, 0, 100, 50, 0, 0, 0);
        frame();
        check_pix(100, 50, 1, 8'h5A, "R11 disabled");
        check_pix(101, 50, 1, 8'h5A, "R11 disabled");

        // R12 settings without a frame pulse
        set_cfg(1, 0, 100, 50, 0, 0, 0);
        check_pix(100, 50, 1, 8'h5A, "R12 no pulse");
        frame();
        cfg_color0 = 8'h99;
        check_pix(100, 50, 1, 8'h5A, "R12 colour held");
        frame();
        check_pix(100, 50, 1, 8'h5A, "R12 colour new");

        // R13 live rewrite
        wr(0, 8'hFF);
        check_pix(100, 50, 1, 8'h5A, "R13 rewrite");

        // random phase
        for (int i = 0; i < 1024; i++) wr(i, 8'($urandom));
        for (int f = 0; f < 8; f++) begin
            int ys;
            cfg_color0 = 8'($urandom); cfg_color1 = 8'($urandom);
            set_cfg(($urandom % 8) != 0, $urandom % 2, $urandom % 300, $urandom % 150,
                    $urandom % 64, $urandom % 64, $urandom % 128);
            frame();
            ys = m_dbl ? 2 * m_py : m_py;
            for (int p = 0; p < 150; p++) begin
                int x, y;
                x = m_px + int'($urandom % 72) - 4;
                y = ys + int'($urandom % (m_dbl ? 136 : 72)) - 4;
                if (x < 0) x = 0;
                if (y < 0) y = 0;
                check_pix(x, y, ($urandom % 8) != 0, 8'($urandom), "R7 random");
            end
        end
        finish_run();
    end

endmodule